// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches the start of every incoming Ethernet frame and takes the six-byte destination MAC address from the byte stream. From that address it decides whether the frame is kept or thrown away. It checks broadcast frames against a reject control. It compares unicast frames with a programmed station address. Multicast frames go through a 64-entry hash table whose index comes from the Ethernet CRC-32 of the destination. A hash-all control sends unicast frames through the hash table as well. A promiscuous control keeps frames that fail filtering and marks them with a miss flag.

The receive datapath feeds bytes in with a valid qualifier, a start-of-frame marker on the first byte and an end-of-frame marker on the last byte. The filter produces one decision strobe per frame, together with registered accept and miss outputs. The decision is held until the next start-of-frame. Storing the frame and checking its FCS are left to other blocks.

Top module: `rx_da_filter`

## Requirements
- R1: Immediately after a synchronous reset, `dec_valid`, `dec_accept` and `dec_miss` are all 0.
- R2: A destination of all ones (every bit of the first six bytes is 1) is a hit when `cfg_bc_reject` is 0 and a miss when it is 1. This rule takes priority over the hash and unicast rules, including when `cfg_hash_all` is 1.
- R3: A destination that is not broadcast is looked up in the hash table if bit 0 of its first byte is 1 or `cfg_hash_all` is 1. Index values 0 to 31 select bit `index` of `cfg_hash_lo`, and values 32 to 63 select bit `index-32` of `cfg_hash_hi`. A set bit is a hit.
- R4: The hash index is bits 31:26 of a CRC-32 with polynomial 0x04C11DB7, preset to all ones and not inverted at the end. The CRC is computed in MSB-first shift form over the six destination bytes in arrival order, with bit 0 of each byte fed first.
- R5: Any other destination is a hit only if it equals the station address. Byte 0 (the first received) must equal `cfg_addr_hi[15:8]`, byte 1 `cfg_addr_hi[7:0]`, byte 2 `cfg_addr_lo[31:24]`, byte 3 `cfg_addr_lo[23:16]`, byte 4 `cfg_addr_lo[15:8]` and byte 5 `cfg_addr_lo[7:0]`.
- R6: A frame whose end-of-frame byte arrives before its sixth byte is a miss, whatever its content.
- R7: A hit gives accept=1, miss=0. A miss with `cfg_promisc`=0 gives accept=0, miss=0, which means the frame is dropped. A miss with `cfg_promisc`=1 gives accept=1, miss=1.
- R8: `dec_valid` pulses for exactly one cycle per frame. The pulse appears two clock edges after the edge that takes the sixth byte, or after the edge that takes the end-of-frame byte of a short frame.
- R9: `dec_accept` and `dec_miss` hold their values until a start-of-frame byte is taken. That edge clears both to 0 until the next decision.
- R10: Bytes after the sixth byte of a frame, and bytes that arrive with `in_valid` high outside a frame (no start-of-frame seen), do not change the decision and do not produce a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present on `in_data` this cycle |
| in_sof | input | 1 | The current byte is the first byte of a frame |
| in_eof | input | 1 | The current byte is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| cfg_bc_reject | input | 1 | Treat broadcast destinations as a miss |
| cfg_hash_all | input | 1 | Look up every non-broadcast destination in the hash table |
| cfg_promisc | input | 1 | Keep missed frames and flag them |
| cfg_addr_hi | input | 16 | Station address bytes 0 and 1 |
| cfg_addr_lo | input | 32 | Station address bytes 2 to 5 |
| cfg_hash_lo | input | 32 | Hash table entries 0 to 31 |
| cfg_hash_hi | input | 32 | Hash table entries 32 to 63 |
| dec_valid | output | 1 | One-cycle strobe: a decision is ready |
| dec_accept | output | 1 | Frame is kept |
| dec_miss | output | 1 | Frame is kept but failed filtering |

## Verification
The decision is due two clock edges after the sixth byte is taken, or after the end-of-frame byte of a short frame. The bench drives bytes on falling edges and counts those edges from the first byte of each frame. It expects the strobe exactly at falling edge index min(length,6)+1 and checks the outputs there. Cleared outputs are expected at falling edge index 1, after the start-of-frame edge. The held value is checked three idle cycles after the frame. A separate counter confirms that each frame produces exactly one strobe.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;
  localparam int unsigned CRC_W    = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

  // One byte into the MSB-first CRC register, bit 0 of the byte first.
  function automatic logic [CRC_W-1:0] crc_feed_byte(input logic [CRC_W-1:0] c,
                                                     input logic [7:0] b);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[CRC_W-1] ^ b[i]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                   r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/rx_da_capture.sv
module rx_da_capture #(
  parameter int BYTE_W   = 8,
  parameter int DA_BYTES = 6,
  parameter int DA_W     = BYTE_W * DA_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [BYTE_W-1:0] in_data,
  output logic              take,
  output logic              first,
  output logic [DA_W-1:0]   da,
  output logic              done_q,
  output logic              short_q
);
  localparam int CNT_W = $clog2(DA_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DA_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos;
  logic             active_q;

  assign first = in_valid && in_sof;
  assign take  = first || (in_valid && active_q);
  assign pos   = in_sof ? '0 : cnt_q;

  // Destination byte store, byte 0 in the low lane.
  always_ff @(posedge clk) begin
    for (int k = 0; k < DA_BYTES; k++) begin
      if (take && pos == CNT_W'(k)) da[k*BYTE_W +: BYTE_W] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      short_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      short_q <= 1'b0;
      if (take) begin
        cnt_q <= pos + 1'b1;
        if (pos == LAST) begin
          done_q   <= 1'b1;
          active_q <= 1'b0;
        end else if (in_eof) begin
          short_q  <= 1'b1;
          active_q <= 1'b0;
        end else begin
          active_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_da_hash.sv
module rx_da_hash
  import rx_da_filter_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              first,
  input  logic [BYTE_W-1:0] in_data,
  output logic [IDX_W-1:0]  idx
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;

  assign crc_base = first ? '1 : crc_q;

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= '1;
    else if (take) crc_q <= crc_feed_byte(crc_base, in_data[7:0]);
  end

  assign idx = crc_q[CRC_W-1 -: IDX_W];
endmodule

// File: rtl/rx_da_decide.sv
module rx_da_decide #(
  parameter int BYTE_W    = 8,
  parameter int DA_BYTES  = 6,
  parameter int HASH_HALF = 32,
  parameter int DA_W      = BYTE_W * DA_BYTES,
  parameter int HI_W      = 2 * BYTE_W,
  parameter int LO_W      = DA_W - HI_W,
  parameter int IDX_W     = $clog2(2 * HASH_HALF)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 done_q,
  input  logic                 short_q,
  input  logic                 first,
  input  logic [DA_W-1:0]      da,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 cfg_bc_reject,
  input  logic                 cfg_hash_all,
  input  logic                 cfg_promisc,
  input  logic [HI_W-1:0]      cfg_addr_hi,
  input  logic [LO_W-1:0]      cfg_addr_lo,
  input  logic [HASH_HALF-1:0] cfg_hash_lo,
  input  logic [HASH_HALF-1:0] cfg_hash_hi,
  output logic                 dec_valid,
  output logic                 dec_accept,
  output logic                 dec_miss
);
  localparam int HI_BYTES = HI_W / BYTE_W;

  logic [DA_W-1:0]        station;
  logic [2*HASH_HALF-1:0] table_w;
  logic                   is_bcast, use_hash, hit, fire;

  // Station address in arrival order: first bytes from the upper word, MSB lane first.
  for (genvar k = 0; k < DA_BYTES; k++) begin : g_station
    if (k < HI_BYTES) begin : g_hi
      assign station[k*BYTE_W +: BYTE_W] = cfg_addr_hi[(HI_BYTES-k)*BYTE_W-1 -: BYTE_W];
    end else begin : g_lo
      assign station[k*BYTE_W +: BYTE_W] = cfg_addr_lo[(DA_BYTES-k)*BYTE_W-1 -: BYTE_W];
    end
  end

  assign table_w  = {cfg_hash_hi, cfg_hash_lo};
  assign is_bcast = &da;
  assign use_hash = da[0] || cfg_hash_all;
  assign fire     = done_q || short_q;

  always_comb begin
    if (short_q)       hit = 1'b0;
    else if (is_bcast) hit = !cfg_bc_reject;
    else if (use_hash) hit = table_w[idx];
    else               hit = (da == station);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_miss   <= 1'b0;
    end else begin
      dec_valid <= fire;
      if (fire) begin
        dec_accept <= hit || cfg_promisc;
        dec_miss   <= !hit && cfg_promisc;
      end else if (first) begin
        dec_accept <= 1'b0;
        dec_miss   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter #(
  parameter int BYTE_W    = 8,
  parameter int DA_BYTES  = 6,
  parameter int HASH_HALF = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic                              in_sof,
  input  logic                              in_eof,
  input  logic [BYTE_W-1:0]                 in_data,
  input  logic                              cfg_bc_reject,
  input  logic                              cfg_hash_all,
  input  logic                              cfg_promisc,
  input  logic [2*BYTE_W-1:0]               cfg_addr_hi,
  input  logic [(DA_BYTES-2)*BYTE_W-1:0]    cfg_addr_lo,
  input  logic [HASH_HALF-1:0]              cfg_hash_lo,
  input  logic [HASH_HALF-1:0]              cfg_hash_hi,
  output logic                              dec_valid,
  output logic                              dec_accept,
  output logic                              dec_miss
);
  localparam int DA_W  = BYTE_W * DA_BYTES;
  localparam int IDX_W = $clog2(2 * HASH_HALF);

  logic             take_w, first_w, done_w, short_w;
  logic [DA_W-1:0]  da_w;
  logic [IDX_W-1:0] idx_w;

  rx_da_capture #(.BYTE_W(BYTE_W), .DA_BYTES(DA_BYTES), .DA_W(DA_W)) u_capture (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .take(take_w), .first(first_w), .da(da_w),
    .done_q(done_w), .short_q(short_w)
  );

  rx_da_hash #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_hash (
    .clk(clk), .rst(rst), .take(take_w), .first(first_w), .in_data(in_data), .idx(idx_w)
  );

  rx_da_decide #(.BYTE_W(BYTE_W), .DA_BYTES(DA_BYTES), .HASH_HALF(HASH_HALF)) u_decide (
    .clk(clk), .rst(rst), .done_q(done_w), .short_q(short_w), .first(first_w),
    .da(da_w), .idx(idx_w), .cfg_bc_reject(cfg_bc_reject), .cfg_hash_all(cfg_hash_all),
    .cfg_promisc(cfg_promisc), .cfg_addr_hi(cfg_addr_hi), .cfg_addr_lo(cfg_addr_lo),
    .cfg_hash_lo(cfg_hash_lo), .cfg_hash_hi(cfg_hash_hi),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_miss(dec_miss)
  );
endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_sof,
  input logic cfg_promisc,
  input logic short_q,
  input logic dec_valid,
  input logic dec_accept,
  input logic dec_miss
);
  AST_MISS_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    dec_miss |-> dec_accept); // R7

  AST_MISS_NEEDS_PROMISC: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_miss) |-> $past(cfg_promisc)); // R7

  AST_STROBE_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(in_valid, 2)); // R8

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    (!dec_valid && !$past(in_valid && in_sof)) |-> ($stable(dec_accept) && $stable(dec_miss))); // R9

  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && in_sof) && !dec_valid) |-> (!dec_accept && !dec_miss)); // R9

  AST_SHORT_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(short_q) && !$past(cfg_promisc)) |-> !dec_accept); // R6
endmodule

bind rx_da_filter rx_da_filter_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .cfg_promisc(cfg_promisc),
  .short_q(short_w), .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_miss(dec_miss)
);

// File: tb/rx_da_filter_test.sv
module rx_da_filter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        cfg_bc_reject = 1'b0, cfg_hash_all = 1'b0, cfg_promisc = 1'b0;
  logic [15:0] cfg_addr_hi = 16'h0211;
  logic [31:0] cfg_addr_lo = 32'h22334455;
  logic [31:0] cfg_hash_lo = '0, cfg_hash_hi = '0;
  logic        dec_valid, dec_accept, dec_miss;

  int checks = 0, fails = 0, pulses = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  rx_da_filter uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .cfg_bc_reject(cfg_bc_reject), .cfg_hash_all(cfg_hash_all),
    .cfg_promisc(cfg_promisc), .cfg_addr_hi(cfg_addr_hi), .cfg_addr_lo(cfg_addr_lo),
    .cfg_hash_lo(cfg_hash_lo), .cfg_hash_hi(cfg_hash_hi),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_miss(dec_miss)
  );

  always @(posedge clk) begin
    #1;
    if (dec_valid) pulses++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reflected-form CRC, index = bit-reverse of the low six bits.
  function automatic int exp_idx(input logic [47:0] da);
    logic [31:0] r;
    logic fb;
    r = '1;
    for (int k = 0; k < 48; k++) begin
      fb = r[0] ^ da[k];
      r  = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    return int'({r[0], r[1], r[2], r[3], r[4], r[5]});
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Send a frame (byte k = fr[8k+:8]); check clear, strobe timing, result, hold, single pulse.
  task automatic send_frame(input logic [63:0] fr, input int len, input bit ea, input bit em,
                            input string req);
    int due, last, p0;
    due  = ((len < 6) ? len : 6) + 1;
    last = (len - 1 > due) ? len - 1 : due;
    p0   = pulses;
    for (int t = 0; t <= last; t++) begin
      @(negedge clk);
      if (t == 1) begin
        chk(dec_accept == 1'b0 && dec_miss == 1'b0, "R9", "sof clears",
            {dec_accept, dec_miss}, 0);
      end
      if (t == due) begin
        chk(dec_valid == 1'b1, "R8", "strobe due", dec_valid, 1);
        chk(dec_accept == ea, req, "accept", dec_accept, ea);
        chk(dec_miss == em, req, "miss", dec_miss, em);
      end else if (t > 0) begin
        chk(dec_valid == 1'b0, "R8", "strobe early/late", dec_valid, 0);
      end
      if (t < len) begin
        in_valid = 1'b1;
        in_sof   = (t == 0);
        in_eof   = (t == len - 1);
        in_data  = fr[8*t +: 8];
      end else begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
    chk(dec_accept == ea && dec_miss == em, "R9", "held", {dec_accept, dec_miss}, {ea, em});
    chk(pulses == p0 + 1, "R8", "one strobe per frame", pulses - p0, 1);
  endtask

  function automatic logic [63:0] station();
    return {16'h0, cfg_addr_lo[7:0], cfg_addr_lo[15:8], cfg_addr_lo[23:16],
            cfg_addr_lo[31:24], cfg_addr_hi[7:0], cfg_addr_hi[15:8]};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [63:0] fr;
    int idx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dec_valid == 0 && dec_accept == 0 && dec_miss == 0, "R1", "reset outputs",
        {dec_valid, dec_accept, dec_miss}, 0);

    // R5 exact unicast match; R7 mismatch per byte with/without promiscuous
    send_frame(station(), 6, 1, 0, "R5");
    for (int j = 0; j < 6; j++) begin
      fr = station() ^ (64'h2 << (8*j));
      cfg_promisc = 1'b0;
      send_frame(fr, 6, 0, 0, "R5/R7 drop");
      cfg_promisc = 1'b1;
      send_frame(fr, 6, 1, 1, "R5/R7 promisc miss");
    end
    cfg_promisc = 1'b0;

    // R2 broadcast rules, also with hash-all and an empty table
    for (int m = 0; m < 8; m++) begin
      cfg_bc_reject = m[0]; cfg_promisc = m[1]; cfg_hash_all = m[2];
      send_frame(64'h0000_FFFF_FFFF_FFFF, 6, !m[0] || m[1], m[0] && m[1], "R2");
    end
    cfg_bc_reject = 0; cfg_promisc = 0; cfg_hash_all = 0;

    // R3/R4 hash sweep over pseudo-random multicast destinations
    for (int n = 0; n < 64; n++) begin
      seed = next_rand(seed);
      fr = {16'h0, seed[15:0], seed} | 64'h1;
      if (fr[47:0] == 48'hFFFF_FFFF_FFFF) fr[8] = 1'b0;
      idx = exp_idx(fr[47:0]);
      {cfg_hash_hi, cfg_hash_lo} = 64'h1 << idx;
      send_frame(fr, 6, 1, 0, "R3/R4 hash hit");
      {cfg_hash_hi, cfg_hash_lo} = ~(64'h1 << idx);
      send_frame(fr, 6, 0, 0, "R3/R4 hash miss");
    end

    // R3 hash-all: matching unicast goes through the table
    cfg_hash_all = 1'b1;
    idx = exp_idx(station()[47:0]);
    {cfg_hash_hi, cfg_hash_lo} = ~(64'h1 << idx);
    send_frame(station(), 6, 0, 0, "R3 hash-all miss");
    {cfg_hash_hi, cfg_hash_lo} = 64'h1 << idx;
    send_frame(station(), 6, 1, 0, "R3 hash-all hit");
    cfg_hash_all = 1'b0;
    {cfg_hash_hi, cfg_hash_lo} = '0;

    // R6 short frames carrying a matching prefix
    for (int l = 1; l < 6; l++) begin
      cfg_promisc = 1'b0;
      send_frame(station(), l, 0, 0, "R6 short drop");
      cfg_promisc = 1'b1;
      send_frame(station(), l, 1, 1, "R6 short promisc");
    end
    cfg_promisc = 1'b0;

    // R10 trailing bytes ignored
    send_frame({16'hBEEF, station()[47:0]}, 8, 1, 0, "R10 trailing bytes");

    // R10 bytes outside a frame: no strobe, decision held
    begin
      int p0;
      p0 = pulses;
      for (int t = 0; t < 8; t++) begin
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b0; in_eof = (t == 7); in_data = 8'hFF;
      end
      @(negedge clk);
      in_valid = 1'b0; in_eof = 1'b0;
      repeat (3) @(negedge clk);
      chk(pulses == p0, "R10", "no strobe outside frame", pulses - p0, 0);
      chk(dec_accept == 1 && dec_miss == 0, "R10", "decision untouched",
          {dec_accept, dec_miss}, 2);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule